// File: doc/BRIEF.md
# Segmented Data Bus Inversion Codec

This block sits between a 64-bit internal data path and a 64-bit active-low bus. The word is cut into four 16-bit lanes, and each lane has its own active-low inversion flag. On a bus wire, a logical one is driven as a low level.

On the transmit side, every lane counts how many of its wires would be pulled low. If that count is greater than half the lane width, the lane goes out inverted and its flag is driven low. The four lanes make this choice in parallel, each with its own population count and compare.

On the receive side, the incoming wires are turned back into logical values. Every lane whose flag arrives low is then inverted again. An enable input can turn inversion off, so that words pass as plain active-low data.

A parameter selects an output register stage. When the stage is present, each direction is loaded by its own valid strobe, and a lane's data and its flag always change on the same edge.

Top module: `seg_inv_codec`

## Requirements
- R1: Lane i (i = 0..3) covers data bits [16i+15:16i]. Flag bit i of `tx_flag_n` and `rx_flag_n` belongs to that lane and to no other.
- R2: With inversion enabled, a lane holding more than 8 logical ones (more than 8 wires that would be low) is sent inverted, and its `tx_flag_n` bit is 0.
- R3: With inversion enabled, a lane holding 8 or fewer logical ones is sent unchanged, and its `tx_flag_n` bit is 1. This includes a lane with exactly 8 ones.
- R4: The bus is active-low. `tx_bus_n` is the bitwise complement of the coded word, so a coded 1 appears as a 0 on the wire, and a flag is asserted when it is 0.
- R5: On receive, `rx_data` is the complement of `rx_bus_n`, with every lane whose `rx_flag_n` bit is 0 inverted once more.
- R6: While `inv_en` is 0, every `tx_flag_n` bit is 1 and `tx_bus_n` equals `~tx_data`, whatever the ones count.
- R7: With the register stage, `tx_bus_n` and `tx_flag_n` load together, one cycle after a clock edge with `tx_valid` high. Otherwise they hold their value.
- R8: With the register stage, `rx_data` loads one cycle after a clock edge with `rx_valid` high. Otherwise it holds its value.
- R9: Feeding the transmit outputs back into the receive inputs returns the original word for every input, including all zeros and all ones.
- R10: With inversion enabled, no transmitted lane ever has more than 8 wires low.
- R11: After reset, `tx_bus_n` and `tx_flag_n` are all ones (idle high), and `rx_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_en | input | 1 | 1 allows lane inversion, 0 bypasses it |
| tx_valid | input | 1 | Loads the transmit output stage |
| tx_data | input | 64 | Internal word to transmit |
| tx_bus_n | output | 64 | Active-low coded data wires |
| tx_flag_n | output | 4 | Active-low per-lane inversion flags |
| rx_valid | input | 1 | Loads the receive output stage |
| rx_bus_n | input | 64 | Active-low received data wires |
| rx_flag_n | input | 4 | Active-low received inversion flags |
| rx_data | output | 64 | Restored internal word |

## Verification
Some properties are checked by assertions on every cycle:
- the output stages hold while their strobes are low;
- no enabled lane ever leaves with more than eight low wires;
- each transmit flag matches the ones count of the word that was loaded;
- bypass keeps every flag high.

Other behaviour only the directed scenarios can show:
- the lane-to-flag mapping;
- the boundary between eight and nine ones;
- the exact wire polarity;
- the reset values;
- loopback recovery of all-zero, all-one and pseudo-random words.

// File: rtl/seg_inv_pkg.sv
package seg_inv_pkg;
    localparam int DATA_W_DEF = 64;
    localparam int LANE_W_DEF = 16;

    function automatic int lane_count(input int data_w, input int lane_w);
        return data_w / lane_w;
    endfunction
endpackage

// File: rtl/seg_lane_enc.sv
module seg_lane_enc #(
    parameter int LANE_W = 16,
    parameter int THRESH = LANE_W / 2
) (
    input  logic [LANE_W-1:0] lane_data,
    input  logic              en,
    output logic [LANE_W-1:0] lane_coded,
    output logic              lane_inv
);
    localparam int CNT_W = $clog2(LANE_W + 1);

    logic [CNT_W-1:0] ones_cnt;

    // Ones in the logical word equal wires that would be pulled low.
    always_comb begin
        ones_cnt = '0;
        for (int b = 0; b < LANE_W; b++) begin
            ones_cnt = ones_cnt + CNT_W'(lane_data[b]);
        end
    end

    always_comb begin
        lane_inv   = en && (ones_cnt > CNT_W'(THRESH));
        lane_coded = lane_inv ? ~lane_data : lane_data;
    end
endmodule

// File: rtl/seg_lane_dec.sv
module seg_lane_dec #(
    parameter int LANE_W = 16
) (
    input  logic [LANE_W-1:0] lane_bus_n,
    input  logic              lane_flag_n,
    output logic [LANE_W-1:0] lane_data
);
    logic [LANE_W-1:0] lane_logic;

    always_comb begin
        lane_logic = ~lane_bus_n;
        lane_data  = lane_flag_n ? lane_logic : ~lane_logic;
    end
endmodule

// File: rtl/seg_inv_codec.sv
module seg_inv_codec #(
    parameter int DATA_W  = seg_inv_pkg::DATA_W_DEF,
    parameter int LANE_W  = seg_inv_pkg::LANE_W_DEF,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   inv_en,
    input  logic                                   tx_valid,
    input  logic [DATA_W-1:0]                      tx_data,
    output logic [DATA_W-1:0]                      tx_bus_n,
    output logic [seg_inv_pkg::lane_count(DATA_W, LANE_W)-1:0] tx_flag_n,
    input  logic                                   rx_valid,
    input  logic [DATA_W-1:0]                      rx_bus_n,
    input  logic [seg_inv_pkg::lane_count(DATA_W, LANE_W)-1:0] rx_flag_n,
    output logic [DATA_W-1:0]                      rx_data
);
    localparam int LANES  = seg_inv_pkg::lane_count(DATA_W, LANE_W);
    localparam int THRESH = LANE_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] tx_bus_n;
        logic [LANES-1:0]  tx_flag_n;
        logic [DATA_W-1:0] rx_data;
    } stage_t;

    logic [DATA_W-1:0] enc_coded;
    logic [LANES-1:0]  enc_inv;
    logic [DATA_W-1:0] dec_data;

    // Per-lane encode and decode, all lanes in parallel.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        seg_lane_enc #(.LANE_W(LANE_W), .THRESH(THRESH)) u_enc (
            .lane_data (tx_data[g*LANE_W +: LANE_W]),
            .en        (inv_en),
            .lane_coded(enc_coded[g*LANE_W +: LANE_W]),
            .lane_inv  (enc_inv[g])
        );
        seg_lane_dec #(.LANE_W(LANE_W)) u_dec (
            .lane_bus_n (rx_bus_n[g*LANE_W +: LANE_W]),
            .lane_flag_n(rx_flag_n[g]),
            .lane_data  (dec_data[g*LANE_W +: LANE_W])
        );
    end

    if (REG_OUT) begin : g_reg
        stage_t stage_d, stage_q;

        always_comb begin
            stage_d = stage_q;
            if (tx_valid) begin
                stage_d.tx_bus_n  = ~enc_coded;
                stage_d.tx_flag_n = ~enc_inv;
            end
            if (rx_valid) begin
                stage_d.rx_data = dec_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q.tx_bus_n  <= '1;
                stage_q.tx_flag_n <= '1;
                stage_q.rx_data   <= '0;
            end else begin
                stage_q <= stage_d;
            end
        end

        assign tx_bus_n  = stage_q.tx_bus_n;
        assign tx_flag_n = stage_q.tx_flag_n;
        assign rx_data   = stage_q.rx_data;

        p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !tx_valid |=> $stable(tx_bus_n) && $stable(tx_flag_n));

        p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !rx_valid |=> $stable(rx_data));

        p_bypass_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
            tx_valid && !inv_en |=> &tx_flag_n);

        for (genvar g = 0; g < LANES; g++) begin : g_chk
            p_low_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
                tx_valid && inv_en |=>
                    $countones(~tx_bus_n[g*LANE_W +: LANE_W]) <= THRESH);

            p_flag_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
                tx_valid && inv_en |=>
                    (!tx_flag_n[g]) ==
                    ($countones($past(tx_data[g*LANE_W +: LANE_W])) > THRESH));
        end
    end else begin : g_comb
        assign tx_bus_n  = ~enc_coded;
        assign tx_flag_n = ~enc_inv;
        assign rx_data   = dec_data;
    end
endmodule

// File: tb/seg_inv_codec_bench.sv
module seg_inv_codec_bench;
    localparam int DW = 64;
    localparam int LW = 16;
    localparam int NL = DW / LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inv_en = 1'b1;
    logic          tx_valid = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic [DW-1:0] tx_bus_n;
    logic [NL-1:0] tx_flag_n;
    logic          rx_valid = 1'b0;
    logic          loop_mode = 1'b0;
    logic [DW-1:0] drv_bus_n = '1;
    logic [NL-1:0] drv_flag_n = '1;
    logic [DW-1:0] rx_bus_n;
    logic [NL-1:0] rx_flag_n;
    logic [DW-1:0] rx_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign rx_bus_n  = loop_mode ? tx_bus_n  : drv_bus_n;
    assign rx_flag_n = loop_mode ? tx_flag_n : drv_flag_n;

    seg_inv_codec u_seg_inv_codec (
        .clk(clk), .rst_n(rst_n), .inv_en(inv_en),
        .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_bus_n(tx_bus_n), .tx_flag_n(tx_flag_n),
        .rx_valid(rx_valid), .rx_bus_n(rx_bus_n),
        .rx_flag_n(rx_flag_n), .rx_data(rx_data)
    );

    // Expected transmit result, derived from R1..R4 and R6.
    function automatic logic [NL-1:0] exp_flags(input logic [DW-1:0] d, input logic en);
        logic [NL-1:0] f;
        for (int i = 0; i < NL; i++) begin
            f[i] = !(en && ($countones(d[i*LW +: LW]) > LW/2));
        end
        return f;
    endfunction

    function automatic logic [DW-1:0] exp_bus(input logic [DW-1:0] d, input logic en);
        logic [NL-1:0] f;
        logic [DW-1:0] c;
        f = exp_flags(d, en);
        c = d;
        for (int i = 0; i < NL; i++) begin
            if (!f[i]) c[i*LW +: LW] = ~d[i*LW +: LW];
        end
        return ~c;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [DW-1:0] d, input logic en);
        @(negedge clk);
        tx_data  = d;
        inv_en   = en;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic check_tx(input string req, input logic [DW-1:0] d, input logic en);
        check(req, tx_bus_n, exp_bus(d, en));
        check(req, DW'(tx_flag_n), DW'(exp_flags(d, en)));
    endtask

    task automatic t_reset;
        check("R11 bus", tx_bus_n, '1);
        check("R11 flags", DW'(tx_flag_n), DW'({NL{1'b1}}));
        check("R11 rx", rx_data, '0);
    endtask

    task automatic t_extremes;
        send('0, 1'b1);
        check("R4 zero bus", tx_bus_n, '1);
        check("R3 zero flags", DW'(tx_flag_n), DW'(4'b1111));
        send('1, 1'b1);
        check("R2 ones bus", tx_bus_n, '1);
        check("R2 ones flags", DW'(tx_flag_n), DW'(4'b0000));
    endtask

    task automatic t_boundary;
        // lane0 = 8 ones, lane1 = 9 ones, lane2 = 7 ones, lane3 = 16 ones
        send(64'hFFFF_007F_01FF_00FF, 1'b1);
        check("R3 R2 flags", DW'(tx_flag_n), DW'(4'b0101));
        check_tx("R3 R2 bus", 64'hFFFF_007F_01FF_00FF, 1'b1);
    endtask

    task automatic t_mapping;
        for (int i = 0; i < NL; i++) begin
            logic [DW-1:0] d;
            logic [NL-1:0] f;
            d = '0;
            d[i*LW +: LW] = 16'h03FF;
            f = '1;
            f[i] = 1'b0;
            send(d, 1'b1);
            check("R1 lane flag", DW'(tx_flag_n), DW'(f));
            check("R4 lane bus", tx_bus_n, exp_bus(d, 1'b1));
        end
    endtask

    task automatic t_bypass;
        send('1, 1'b0);
        check("R6 flags", DW'(tx_flag_n), DW'({NL{1'b1}}));
        check("R6 bus", tx_bus_n, '0);
    endtask

    task automatic t_hold;
        send(64'h1234_5678_9ABC_DEF0, 1'b1);
        @(negedge clk);
        tx_data = '1;
        @(negedge clk);
        check_tx("R7 hold", 64'h1234_5678_9ABC_DEF0, 1'b1);
    endtask

    task automatic t_rx_direct;
        loop_mode = 1'b0;
        @(negedge clk);
        drv_bus_n  = 64'h0000_FFFF_0F0F_1234;
        drv_flag_n = 4'b0110;
        rx_valid   = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        check("R5 decode", rx_data, 64'h0000_0000_F0F0_1234);
        drv_bus_n = '0;
        @(negedge clk);
        check("R8 hold", rx_data, 64'h0000_0000_F0F0_1234);
    endtask

    task automatic t_loop;
        logic [DW-1:0] d;
        loop_mode = 1'b1;
        for (int n = 0; n < 40; n++) begin
            if (n == 0) d = '0;
            else if (n == 1) d = '1;
            else d = {$urandom, $urandom};
            @(negedge clk);
            tx_data  = d;
            inv_en   = 1'b1;
            tx_valid = 1'b1;
            rx_valid = 1'b1;
            @(negedge clk);
            tx_valid = 1'b0;
            @(negedge clk);
            check("R9 loopback", rx_data, d);
        end
        rx_valid  = 1'b0;
        loop_mode = 1'b0;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_extremes();
        t_boundary();
        t_mapping();
        t_bypass();
        t_hold();
        t_rx_direct();
        t_loop();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule